// File: doc/BRIEF.md
# Programmable Quadrature LO Divider

This block divides a fast oscillator clock down to a pair of local-oscillator clocks for a quadrature mixer. One output is the in-phase clock and the other is the quadrature clock. The quadrature clock lags the in-phase clock by a quarter of the output period. A 2-bit select picks one of four division ratios: 2, 3, 4 or 6.

The quarter-period lag is a whole or half number of input cycles for every ratio except 3. To reach half-cycle resolution, the block uses both edges of the input clock. Flops on the rising edge and flops on the falling edge each hold a half-cycle slot, and the input clock steers between them onto the output.

An enable input stops both outputs for sleep and slotted operation. A change of the select code waits for the next in-phase rising edge, so no output pulse is ever cut short.

Top module: `quad_lo_div`

## Requirements
- R1: The select codes map to ratios as follows: `ratio_sel` 2'b00 divides by 2, 2'b01 by 3, 2'b10 by 4 and 2'b11 by 6.
- R2: For ratios 2, 4 and 6, `lo_q` equals `lo_i` delayed by exactly N/2 input half-cycles, which is a quarter of the output period. `lo_i` therefore leads.
- R3: For ratio 3, `lo_i` is high for the first 3 of every 6 input half-cycles. `lo_q` is the same waveform delayed by 2 half-cycles (one input cycle). This approximates the ideal 0.75-cycle lag, and the I-leads-Q order is kept.
- R4: Both outputs repeat every N input cycles, where N is the selected ratio.
- R5: A new `ratio_sel` value is loaded only when a new in-phase period begins. That happens either at the rising edge where the old period completes or at a start from idle. The period already running finishes unchanged.
- R6: While `en` is low, both outputs are low from the next rising input edge on. After `en` returns high, output period 0 starts at the next rising edge, with `lo_i` rising and `lo_q` low.
- R7: While the synchronous reset `rst` is high, both outputs are low. `rst` also returns the held ratio code to 2'b00.
- R8: For the even ratios, each output is high for exactly N of every 2N input half-cycles, giving a 50 percent duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds both outputs low |
| ratio_sel | input | 2 | Division ratio select code |
| lo_i | output | 1 | In-phase divided clock |
| lo_q | output | 1 | Quadrature divided clock |

## Verification
The bench models the outputs as a sequence of input half-cycle slots. It samples once in each slot, a quarter input period after the edge that opens the slot. The outputs change only at clock edges, so every sample lands between two edges.

A change on `en`, `rst` or `ratio_sel` is driven just after a high-phase sample. Its effect is therefore due at the very next rising edge for `en` and `rst`. For `ratio_sel`, the effect is due at the first rising edge that opens a new period. The bench model applies each change at exactly that slot boundary, so every slot afterwards is compared against the arithmetically expected level.

// File: rtl/quad_lo_div.sv
`timescale 1ns/1ps
module quad_lo_div #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] ratio_sel,
  output logic       lo_i,
  output logic       lo_q
);
  localparam int SLOT_W = CNT_W + 1;

  logic [1:0]       sel_r;
  logic [CNT_W-1:0] cnt, cnt_nx, n_cur, n_new;
  logic             run, wrap;
  logic             i_p, q_p, i_n, q_n;

  function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] c);
    case (c)
      2'b00:   return CNT_W'(2);
      2'b01:   return CNT_W'(3);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction

  function automatic logic hi_i(input logic [SLOT_W-1:0] h, input logic [CNT_W-1:0] n);
    return h < {1'b0, n};
  endfunction

  function automatic logic hi_q(input logic [SLOT_W-1:0] h, input logic [CNT_W-1:0] n);
    logic [SLOT_W:0] s, n2, d;
    n2 = {1'b0, n, 1'b0};
    d  = ({2'b0, n} + 1'b1) >> 1;
    s  = {1'b0, h} + n2 - d;
    if (s >= n2) s = s - n2;
    return s < {2'b0, n};
  endfunction

  assign n_cur  = ratio_of(sel_r);
  assign n_new  = ratio_of(ratio_sel);
  assign cnt_nx = cnt + 1'b1;
  assign wrap   = (cnt == n_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run <= 1'b0;
      cnt <= '0;
      i_p <= 1'b0;
      q_p <= 1'b0;
      if (rst) sel_r <= 2'b00;
    end else if (!run || wrap) begin
      run   <= 1'b1;
      cnt   <= '0;
      sel_r <= ratio_sel;
      i_p   <= hi_i('0, n_new);
      q_p   <= hi_q('0, n_new);
    end else begin
      cnt <= cnt_nx;
      i_p <= hi_i({cnt_nx, 1'b0}, n_cur);
      q_p <= hi_q({cnt_nx, 1'b0}, n_cur);
    end
  end

  always_ff @(negedge clk) begin
    if (!run) begin
      i_n <= 1'b0;
      q_n <= 1'b0;
    end else begin
      i_n <= hi_i({cnt, 1'b1}, n_cur);
      q_n <= hi_q({cnt, 1'b1}, n_cur);
    end
  end

  assign lo_i = clk ? i_p : i_n;
  assign lo_q = clk ? q_p : q_n;
endmodule

// File: rtl/quad_lo_div_chk.sv
module quad_lo_div_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             run,
  input logic [1:0]       sel_r,
  input logic [CNT_W-1:0] cnt,
  input logic             i_p,
  input logic             q_p,
  input logic             i_n,
  input logic             q_n
);
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < ((sel_r == 2'b00) ? 2 : (sel_r == 2'b01) ? 3 : (sel_r == 2'b10) ? 4 : 6)));

  p_q_low_at_i_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(i_p) |-> !q_p);

  p_sel_at_period_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_r) |-> $rose(i_p));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!i_p && !q_p));

  p_restart_phase_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0 && i_p && !q_p));

  p_neg_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!i_n && !q_n));
endmodule

bind quad_lo_div quad_lo_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .run(run), .sel_r(sel_r), .cnt(cnt),
  .i_p(i_p), .q_p(q_p), .i_n(i_n), .q_n(q_n)
);

// File: tb/quad_lo_div_test.sv
`timescale 1ns/1ps
module quad_lo_div_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       lo_i, lo_q;

  always #2.5 clk = ~clk;

  quad_lo_div uut (.clk(clk), .rst(rst), .en(en), .ratio_sel(sel), .lo_i(lo_i), .lo_q(lo_q));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int h = 0, n = 2, ph = 0;
  bit active = 0;

  // R1 code-to-ratio mapping
  function automatic int rat(input int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic bit exp_i(input int hh, input int nn);
    return hh < nn;
  endfunction

  function automatic bit exp_q(input int hh, input int nn);
    int d = (nn + 1) / 2;
    return ((hh + 2 * nn - d) % (2 * nn)) < nn;
  endfunction

  task automatic chk(input logic act, input bit exp, input string nm, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic advance();
    ph ^= 1;
    if (ph == 0) begin
      if (rst || !en) active = 0;
      else if (!active) begin active = 1; h = 0; n = rat(sel); end
      else begin
        h++;
        if (h == 2 * n) begin h = 0; n = rat(sel); end
      end
    end else if (active) h++;
  endtask

  task automatic slots(input int k, input string tag);
    for (int s = 0; s < k; s++) begin
      chk(lo_i, active ? exp_i(h, n) : 1'b0, "lo_i", tag);
      chk(lo_q, active ? exp_q(h, n) : 1'b0, "lo_q", tag);
      #2.5;
      advance();
    end
  endtask

  initial begin
    @(posedge clk);
    #1.25;
    ph = 0;
    slots(4, "R7");
    rst = 1'b0;
    for (int c = 0; c < 4; c++) begin
      sel = 2'(c);
      en = 1'b1;
      slots(16 * rat(c) + 2, (c == 1) ? "R1 R3 R4" : "R1 R2 R4 R8");
      en = 1'b0;
      slots(6, "R6");
    end
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          sel = 2'(a);
          en = 1'b1;
          slots(4 * rat(a) + 2 * ((a + b) % 3) + 2, "R5");
          sel = 2'(b);
          slots(48, "R5");
          en = 1'b0;
          slots(4, "R6");
        end
      end
    end
    sel = 2'b11;
    en = 1'b1;
    slots(10, "R7");
    rst = 1'b1;
    slots(4, "R7");
    rst = 1'b0;
    slots(30, "R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000.0;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule